// File: doc/BRIEF.md
# Instruction-Indexed Stride Prefetcher

This block watches the stream of load accesses in a core. Each access arrives with the address of the load instruction that issued it and the data address it touched. History is kept per load instruction, not per data region. A small direct-mapped table, indexed by low bits of the instruction address, holds for each instruction the last data address it used, the distance between its two most recent accesses, and a small confidence count.

When one instruction keeps moving through memory by the same distance, the block gains confidence in that stride. Once confident, it requests the 64-byte line at the current address plus the stride. Strides may be positive or negative. Requests are withheld when:
- the stride is zero or larger than 2 KB in magnitude,
- the predicted line is the line just accessed,
- the prediction leaves the current 4 KB page,
- the global enable input is low.

The request is a single registered valid/line pair, one per observed access at most.

Top module: `ip_stride_prefetch`

## Requirements
- R1: The table entry is chosen by `ld_pc[5:0]`. Its tag is the XOR-fold of `ld_pc[31:6]` into 8 bits: bit k of the tag is the XOR of every `ld_pc` bit b ≥ 6 with (b−6) mod 8 = k. When the access finds an invalid entry or a different tag, the entry is reloaded with the new tag and address, a zero stride and zero confidence. Such an access never produces a request.
- R2: On a tag hit, the observed stride is the current data address minus the entry's stored address, using 32-bit two's-complement arithmetic. If the observed stride equals the stored one, confidence rises by one and saturates at 3. Otherwise the stride is replaced and confidence returns to 0. The stored address always becomes the current address.
- R3: A request is raised when a tag hit repeats the stored stride S, the confidence after the update is at least 2, and none of the filters in R4–R9 apply. The request line is `(ld_addr + S) >> 6`. With a steady non-zero stride, the fourth access of an instruction is the first that can raise one.
- R4: Only strides with magnitude at most 2048 bytes can raise a request. A stride of exactly 2048 can; 2049 or more cannot.
- R5: Negative strides are predicted in the same way as positive ones.
- R6: A zero stride never raises a request.
- R7: No request is raised when the predicted line equals the line of the current access.
- R8: No request is raised when the predicted address lies in a different 4 KB page (`[31:12]`) from the current access.
- R9: While `pf_enable` is low, no request is raised, but the table keeps learning. After enable returns high, the very next qualifying access raises a request.
- R10: The request appears on `pf_valid`/`pf_line` after the clock edge that samples the access, and is held for one cycle only. `pf_valid` is low in a cycle that follows no access. Reset invalidates every entry and clears `pf_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | A load access is presented this cycle |
| ld_pc | input | 32 | Instruction address of the load |
| ld_addr | input | 32 | Byte data address of the load |
| pf_enable | input | 1 | Global permission to raise requests |
| pf_valid | output | 1 | A prefetch request is present |
| pf_line | output | 26 | Line address (byte address >> 6) of the request |

## Verification
Every result of this block is due one clock edge after the edge that samples the access. The table update and the output register both take effect at that same edge. The bench therefore drives each access half a cycle before a rising edge and compares `pf_valid` and `pf_line` one time unit after that edge, against a prediction its behavioural model made for that access. Cycles with no access are compared the same way and must show no request. A test of one stream is thus never masked by the request of a neighbouring cycle.

// File: rtl/ipsp_pkg.sv
package ipsp_pkg;
  // What the table does with the indexed entry in a cycle.
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_ALLOC = 2'd1,
    ACT_TRAIN = 2'd2
  } ipsp_act_e;
endpackage

// File: rtl/ipsp_index.sv
// Splits an instruction address into a table index and a folded tag.
module ipsp_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int TAG_W = 8
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  assign idx = pc[IDX_W-1:0];

  // Every address bit above the index lands on tag bit (b - IDX_W) mod TAG_W.
  always_comb begin
    tag = '0;
    for (int b = IDX_W; b < PC_W; b++) begin
      tag[(b - IDX_W) % TAG_W] = tag[(b - IDX_W) % TAG_W] ^ pc[b];
    end
  end
endmodule

// File: rtl/ipsp_table.sv
// Direct-mapped history storage: asynchronous read, one write per cycle.
module ipsp_table #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6,
  parameter int TAG_W   = 8,
  parameter int ADDR_W  = 32,
  parameter int CONF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_last,
  output logic [ADDR_W-1:0] rd_stride,
  output logic [CONF_W-1:0] rd_conf,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [ADDR_W-1:0] wr_last,
  input  logic [ADDR_W-1:0] wr_stride,
  input  logic [CONF_W-1:0] wr_conf
);
  logic              valid_q  [ENTRIES];
  logic [TAG_W-1:0]  tag_q    [ENTRIES];
  logic [ADDR_W-1:0] last_q   [ENTRIES];
  logic [ADDR_W-1:0] stride_q [ENTRIES];
  logic [CONF_W-1:0] conf_q   [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ENTRIES; e++) begin
        valid_q[e]  <= 1'b0;
        tag_q[e]    <= '0;
        last_q[e]   <= '0;
        stride_q[e] <= '0;
        conf_q[e]   <= '0;
      end
    end else if (wr_en) begin
      valid_q[wr_idx]  <= 1'b1;
      tag_q[wr_idx]    <= wr_tag;
      last_q[wr_idx]   <= wr_last;
      stride_q[wr_idx] <= wr_stride;
      conf_q[wr_idx]   <= wr_conf;
    end
  end

  assign rd_valid  = valid_q[rd_idx];
  assign rd_tag    = tag_q[rd_idx];
  assign rd_last   = last_q[rd_idx];
  assign rd_stride = stride_q[rd_idx];
  assign rd_conf   = conf_q[rd_idx];
endmodule

// File: rtl/ipsp_predict.sv
// Decides, from the indexed entry and the current access, how to train and whether to request.
module ipsp_predict #(
  parameter int ADDR_W     = 32,
  parameter int TAG_W      = 8,
  parameter int CONF_W     = 2,
  parameter int LINE_W     = 6,
  parameter int PAGE_W     = 12,
  parameter int MAX_STRIDE = 2048,
  parameter int FIRE_AT    = 2
) (
  input  logic              ld_valid,
  input  logic [TAG_W-1:0]  cur_tag,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic              ent_valid,
  input  logic [TAG_W-1:0]  ent_tag,
  input  logic [ADDR_W-1:0] ent_last,
  input  logic [ADDR_W-1:0] ent_stride,
  input  logic [CONF_W-1:0] ent_conf,
  output logic              hit,
  output logic              alloc,
  output logic              stride_match,
  output logic [ADDR_W-1:0] new_stride,
  output logic [CONF_W-1:0] conf_next,
  output logic [ADDR_W-1:0] pred_addr,
  output logic              fire
);
  localparam logic signed [ADDR_W-1:0] MAX_S  = ADDR_W'(MAX_STRIDE);
  localparam logic signed [ADDR_W-1:0] MIN_S  = -MAX_S;
  localparam logic [CONF_W-1:0]        FIRE_C = CONF_W'(FIRE_AT);

  function automatic logic [CONF_W-1:0] conf_step(input logic [CONF_W-1:0] c,
                                                  input logic rep);
    if (!rep)     return '0;
    if (&c)       return c;
    return c + CONF_W'(1);
  endfunction

  function automatic logic stride_in_range(input logic signed [ADDR_W-1:0] s);
    return (s <= MAX_S) && (s >= MIN_S);
  endfunction

  function automatic logic line_differs(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] b);
    return a[ADDR_W-1:LINE_W] != b[ADDR_W-1:LINE_W];
  endfunction

  function automatic logic page_same(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] b);
    return a[ADDR_W-1:PAGE_W] == b[ADDR_W-1:PAGE_W];
  endfunction

  logic conf_ok, stride_ok;

  assign hit          = ld_valid && ent_valid && (ent_tag == cur_tag);
  assign alloc        = ld_valid && !hit;
  assign new_stride   = cur_addr - ent_last;
  assign stride_match = hit && (new_stride == ent_stride);
  assign conf_next    = conf_step(ent_conf, stride_match);
  assign pred_addr    = cur_addr + new_stride;
  assign conf_ok      = conf_next >= FIRE_C;
  assign stride_ok    = (new_stride != '0) && stride_in_range(new_stride);
  assign fire         = stride_match && conf_ok && stride_ok
                        && line_differs(pred_addr, cur_addr)
                        && page_same(pred_addr, cur_addr);
endmodule

// File: rtl/ip_stride_prefetch.sv
module ip_stride_prefetch #(
  parameter int PC_W       = 32,
  parameter int ADDR_W     = 32,
  parameter int ENTRIES    = 64,
  parameter int TAG_W      = 8,
  parameter int CONF_W     = 2,
  parameter int LINE_BYTES = 64,
  parameter int PAGE_BYTES = 4096,
  parameter int MAX_STRIDE = 2048,
  parameter int FIRE_AT    = 2,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int LINE_W    = $clog2(LINE_BYTES),
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int LADDR_W   = ADDR_W - LINE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  input  logic [PC_W-1:0]    ld_pc,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic               pf_enable,
  output logic               pf_valid,
  output logic [LADDR_W-1:0] pf_line
);
  import ipsp_pkg::*;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  cur_tag;
  logic              ent_valid;
  logic [TAG_W-1:0]  ent_tag;
  logic [ADDR_W-1:0] ent_last, ent_stride;
  logic [CONF_W-1:0] ent_conf;

  // Named internal events, observed by the bound checker.
  logic              hit, alloc, stride_match, fire;
  logic [ADDR_W-1:0] new_stride, pred_addr;
  logic [CONF_W-1:0] conf_next;

  ipsp_act_e         act;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_stride;
  logic [CONF_W-1:0] wr_conf;

  ipsp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_index (
    .pc  (ld_pc),
    .idx (idx),
    .tag (cur_tag)
  );

  ipsp_table #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W),
    .ADDR_W(ADDR_W), .CONF_W(CONF_W)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (idx),
    .rd_valid  (ent_valid),
    .rd_tag    (ent_tag),
    .rd_last   (ent_last),
    .rd_stride (ent_stride),
    .rd_conf   (ent_conf),
    .wr_en     (wr_en),
    .wr_idx    (idx),
    .wr_tag    (cur_tag),
    .wr_last   (ld_addr),
    .wr_stride (wr_stride),
    .wr_conf   (wr_conf)
  );

  ipsp_predict #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .CONF_W(CONF_W), .LINE_W(LINE_W),
    .PAGE_W(PAGE_W), .MAX_STRIDE(MAX_STRIDE), .FIRE_AT(FIRE_AT)
  ) u_predict (
    .ld_valid     (ld_valid),
    .cur_tag      (cur_tag),
    .cur_addr     (ld_addr),
    .ent_valid    (ent_valid),
    .ent_tag      (ent_tag),
    .ent_last     (ent_last),
    .ent_stride   (ent_stride),
    .ent_conf     (ent_conf),
    .hit          (hit),
    .alloc        (alloc),
    .stride_match (stride_match),
    .new_stride   (new_stride),
    .conf_next    (conf_next),
    .pred_addr    (pred_addr),
    .fire         (fire)
  );

  always_comb begin
    if (!ld_valid)  act = ACT_NONE;
    else if (alloc) act = ACT_ALLOC;
    else            act = ACT_TRAIN;
  end

  always_comb begin
    wr_en     = 1'b0;
    wr_stride = '0;
    wr_conf   = '0;
    case (act)
      ACT_ALLOC: wr_en = 1'b1;
      ACT_TRAIN: begin
        wr_en     = 1'b1;
        wr_stride = new_stride;
        wr_conf   = conf_next;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_line  <= '0;
    end else begin
      pf_valid <= fire && pf_enable;
      if (fire) pf_line <= pred_addr[ADDR_W-1:LINE_W];
    end
  end
endmodule

// File: rtl/ipsp_checker.sv
module ipsp_checker #(
  parameter int ADDR_W  = 32,
  parameter int LINE_W  = 6,
  parameter int PAGE_W  = 12,
  localparam int LADDR_W = ADDR_W - LINE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ld_valid,
  input logic [ADDR_W-1:0]  ld_addr,
  input logic               pf_enable,
  input logic               pf_valid,
  input logic [LADDR_W-1:0] pf_line,
  input logic               alloc,
  input logic               hit,
  input logic               fire
);
  // R10: a request only follows a cycle that carried an access
  a_r10_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(ld_valid));

  // R9: a request only follows a cycle with enable high
  a_r9_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(pf_enable));

  // R8: the requested line stays in the page of the access that caused it
  a_r8_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_line[LADDR_W-1:PAGE_W-LINE_W] == $past(ld_addr[ADDR_W-1:PAGE_W]));

  // R7: the requested line differs from the line just accessed
  a_r7_new_line: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> pf_line != $past(ld_addr[ADDR_W-1:LINE_W]));

  // R1: a reallocating access is silent
  a_r1_alloc_silent: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> !pf_valid);

  // R1: a prediction needs a tag hit
  a_r1_fire_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> hit);
endmodule

bind ip_stride_prefetch ipsp_checker #(
  .ADDR_W(ADDR_W), .LINE_W(LINE_W), .PAGE_W(PAGE_W)
) u_ipsp_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .ld_valid  (ld_valid),
  .ld_addr   (ld_addr),
  .pf_enable (pf_enable),
  .pf_valid  (pf_valid),
  .pf_line   (pf_line),
  .alloc     (alloc),
  .hit       (hit),
  .fire      (fire)
);

// File: tb/ip_stride_prefetch_bench.sv
`timescale 1ns/1ps
module ip_stride_prefetch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_pc = '0;
  logic [31:0] ld_addr = '0;
  logic        pf_enable = 1'b1;
  logic        pf_valid;
  logic [25:0] pf_line;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Behavioural reference table
  bit     m_valid [64];
  int     m_tag   [64];
  longint m_last  [64];
  longint m_str   [64];
  int     m_conf  [64];

  always #2.5 clk = ~clk;

  ip_stride_prefetch u_ip_stride_prefetch (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_pc(ld_pc),
    .ld_addr(ld_addr), .pf_enable(pf_enable), .pf_valid(pf_valid), .pf_line(pf_line)
  );

  function automatic int fold_tag(longint pc);
    longint up = pc >> 6;
    int t = 0;
    while (up != 0) begin
      t = t ^ int'(up & 255);
      up = up >> 8;
    end
    return t;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 64; i++) begin
      m_valid[i] = 0; m_tag[i] = 0; m_last[i] = 0; m_str[i] = 0; m_conf[i] = 0;
    end
  endtask

  task automatic compare(input bit ev, input longint eline, input string req);
    checks++;
    if (pf_valid !== ev || (ev && pf_line !== eline[25:0])) begin
      failures++;
      $display("FAIL %s: pf_valid=%0b pf_line=%h expected valid=%0b line=%h",
               req, pf_valid, pf_line, ev, eline[25:0]);
    end
  endtask

  task automatic access(input longint pc, input longint addr, input bit en, input string req);
    int idx, tg;
    longint s, pred;
    bit ev, same;
    longint eline;
    idx = int'(pc & 63);
    tg  = fold_tag(pc);
    ev = 0; eline = 0;
    if (!m_valid[idx] || m_tag[idx] != tg) begin
      m_valid[idx] = 1; m_tag[idx] = tg; m_last[idx] = addr; m_str[idx] = 0; m_conf[idx] = 0;
    end else begin
      s = addr - m_last[idx];
      same = (s == m_str[idx]);
      if (same) m_conf[idx] = (m_conf[idx] < 3) ? m_conf[idx] + 1 : 3;
      else begin m_conf[idx] = 0; m_str[idx] = s; end
      m_last[idx] = addr;
      pred = addr + s;
      if (en && same && m_conf[idx] >= 2 && s != 0 && s <= 2048 && s >= -2048 &&
          (pred >> 6) != (addr >> 6) && (pred >> 12) == (addr >> 12)) begin
        ev = 1; eline = pred >> 6;
      end
    end
    @(negedge clk);
    ld_valid = 1'b1; ld_pc = pc[31:0]; ld_addr = addr[31:0]; pf_enable = en;
    @(posedge clk); #1;
    ld_valid = 1'b0;
    compare(ev, eline, req);
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    ld_valid = 1'b0;
    @(posedge clk); #1;
    compare(1'b0, 0, req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; ld_valid = 1'b0;
    repeat (2) @(posedge clk);
    #1; model_clear();
    compare(1'b0, 0, "R10");       // R10: output cleared in reset
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    idle("R10");
    // R3 / R5: two instructions interleaved, +64 and -128
    for (int i = 0; i < 6; i++) begin
      access(32'h04, 32'h10000 + 64 * i, 1, "R3");
      access(32'h09, 32'h20F80 - 128 * i, 1, "R5");
    end
    idle("R10");
    // R2: stride of the first instruction changes to 192
    for (int i = 1; i <= 5; i++) access(32'h04, 32'h10140 + 192 * i, 1, "R2");
    // R6: zero stride
    for (int i = 0; i < 5; i++) access(32'h0C, 32'h40000, 1, "R6");
    // R7: small stride, predicted line often the current one
    for (int i = 0; i < 8; i++) access(32'h11, 32'h50000 + 16 * i, 1, "R7");
    // R8: page crossing
    for (int i = 0; i < 7; i++) access(32'h13, 32'h30000 + 1024 * i, 1, "R8");
    // R4: limit stride accepted, stride just above it refused
    for (int i = 0; i < 6; i++) access(32'h15, 32'h60000 + 2048 * i, 1, "R4");
    for (int i = 0; i < 8; i++) access(32'h17, 32'h70000 + 2052 * i, 1, "R4");
    // R9: learning continues while disabled
    for (int i = 0; i < 5; i++) access(32'h19, 32'h80000 + 64 * i, 0, "R9");
    for (int i = 5; i < 7; i++) access(32'h19, 32'h80000 + 64 * i, 1, "R9");
    // R1: two instructions sharing an index keep evicting each other
    for (int i = 0; i < 8; i++) begin
      access(32'h1B, 32'h90000 + 64 * i, 1, "R1");
      access(32'h5B, 32'hA0000 + 64 * i, 1, "R1");
    end
    idle("R10");
    // R10: reset forgets a trained entry
    do_reset();
    for (int i = 6; i < 11; i++) access(32'h04, 32'h10000 + 64 * i, 1, "R10");
    idle("R10");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule